// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the three-wire serial slave front end of a multi-channel converter controller. While the active-low select/load strobe `sel_ld_n` is low, every rising edge of `sck` samples `sdi` into a 32-bit shift register. When the strobe rises, the transfer ends. The 24 most recently shifted bits are latched as a 4-bit command, a 4-bit channel address and a 16-bit data word. A one-cycle execute pulse in the system clock domain then tells the register bank that a new word is ready.

The register's top bit is driven onto `sdo` on falling edges of `sck`, so several receivers can be chained. In a chain, each device's `sdo` feeds the next device's `sdi`, and all devices share `sck` and the strobe. The first word shifted into the chain lands in the last device. All devices act together on the shared strobe rise. The shift register is never cleared by the strobe, so data passing through the chain survives between frames. Frames may be 24 or 32 bits long, and longer streams also work, because decoding always uses the last 24 bits.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `sel_ld_n` is high, `sck` edges are ignored: the shift register, `sdo` and the execute path do not change.
- R2: While `sel_ld_n` is low, each rising edge of `sck` moves the register one place toward its top bit and puts `sdi` into bit 0.
- R3: Of the last 24 bits shifted, the first 4 form the command (`cmd_o`), the next 4 form the address (`addr_o`), and the final 16 form `data_o`, MSB first.
- R4: A 24-bit frame and a 32-bit frame with 8 leading don't-care bits decode identically. Any frame length decodes from its last 24 bits.
- R5: Each rising edge of `sel_ld_n` latches the fields and produces exactly one `exec_pulse`, one `clk` cycle wide, after a two-flop synchroniser and an edge detector. The fields are stable while the pulse is high.
- R6: A bit sampled on rising edge n of `sck` drives `sdo` from the falling edge that follows rising edge n+31. `sdo` changes only on falling edges while `sel_ld_n` is low.
- R7: The strobe does not clear the shift register, so bits from one frame continue to emerge on `sdo` during the next frame.
- R8: After reset, `sdo`, `exec_pulse` and all fields are 0, and the shift register holds zeros.
- R9: With two receivers chained `sdo` to `sdi`, a 64-bit stream delivers its first 32 bits to the second device and its last 32 bits to the first device. Both execute on the same strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising `sck` |
| sel_ld_n | input | 1 | Active-low select; its rising edge loads and executes |
| sdo | output | 1 | Serial data out, updated on falling `sck` |
| exec_pulse | output | 1 | One `clk` cycle execute strobe |
| cmd_o | output | 4 | Latched command field |
| addr_o | output | 4 | Latched address field |
| data_o | output | 16 | Latched data word |

## Verification
Two functions can fall in the same cycle. On the final falling edge of a frame, `sdo` emits a bit carried over from earlier shifting. Shortly after that edge, the strobe rise latches the fields and launches the execute pulse. The bench provokes this with back-to-back frames of 24, 32, 40 and 64 bits through a two-device chain. It judges `sdo` on every selected falling edge against a bit-history model with a 32-edge delay. Each execute pulse is popped from a scoreboard queue that holds the last 24 bits of each device's history. A missing pulse, an extra pulse or a mismatched field is reported.

// File: rtl/scrx_pkg.sv
package scrx_pkg;
    parameter int CMD_W   = 4;
    parameter int ADDR_W  = 4;
    parameter int DATA_W  = 16;
    parameter int SHIFT_W = 32;
    localparam int WORD_W = CMD_W + ADDR_W + DATA_W;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scrx_word_t;
endpackage

// File: rtl/scrx_shifter.sv
module scrx_shifter #(
    parameter int W = 32
) (
    input  logic         sck,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] shift_q
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic         so;
    } shf_t;

    shf_t nxt_d;
    logic [W-1:0] sr_q;
    logic         so_q;

    always_comb begin
        nxt_d.sr = sr_q;
        nxt_d.so = so_q;
        if (!sel_n) begin
            nxt_d.sr = {sr_q[W-2:0], sdi};
            nxt_d.so = sr_q[W-1];
        end
    end

    // shift on the rising serial edge
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= nxt_d.sr;
    end

    // present the top bit on the falling serial edge
    always_ff @(negedge sck or negedge rst_n) begin
        if (!rst_n) so_q <= 1'b0;
        else        so_q <= nxt_d.so;
    end

    assign sdo     = so_q;
    assign shift_q = sr_q;
endmodule

// File: rtl/scrx_loader.sv
module scrx_loader
    import scrx_pkg::*;
(
    input  logic              ld_n,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tail_i,
    output scrx_word_t        word_o,
    output logic              toggle_o
);
    typedef struct packed {
        scrx_word_t word;
        logic       tog;
    } ldr_t;

    ldr_t ld_d, ld_q;

    always_comb begin
        ld_d.word = scrx_word_t'(tail_i);
        ld_d.tog  = ~ld_q.tog;
    end

    always_ff @(posedge ld_n or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign word_o   = ld_q.word;
    assign toggle_o = ld_q.tog;
endmodule

// File: rtl/scrx_pulse_sync.sv
module scrx_pulse_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic pulse_o
);
    localparam int CHAIN_W = SYNC_DEPTH + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], toggle_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // one cycle per toggle: compare last synchronised stage with the edge-detect stage
    assign pulse_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import scrx_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sel_ld_n,
    output logic              sdo,
    output logic              exec_pulse,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    logic [SHIFT_W-1:0] shift_word;
    scrx_word_t         held_word;
    logic               load_toggle;

    scrx_shifter #(.W(SHIFT_W)) u_shift (
        .sck     (sck),
        .rst_n   (rst_n),
        .sel_n   (sel_ld_n),
        .sdi     (sdi),
        .sdo     (sdo),
        .shift_q (shift_word)
    );

    scrx_loader u_load (
        .ld_n     (sel_ld_n),
        .rst_n    (rst_n),
        .tail_i   (shift_word[WORD_W-1:0]),
        .word_o   (held_word),
        .toggle_o (load_toggle)
    );

    scrx_pulse_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (load_toggle),
        .pulse_o  (exec_pulse)
    );

    assign cmd_o  = held_word.cmd;
    assign addr_o = held_word.addr;
    assign data_o = held_word.data;
endmodule

// File: rtl/scrx_checker.sv
module scrx_checker
    import scrx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sck,
    input logic               sdi,
    input logic               sel_ld_n,
    input logic               exec_pulse,
    input logic [SHIFT_W-1:0] shift_word,
    input logic [CMD_W-1:0]   cmd_o,
    input logic [ADDR_W-1:0]  addr_o,
    input logic [DATA_W-1:0]  data_o
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |=> !exec_pulse); // R5

    AST_FIELDS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> ($stable(cmd_o) && $stable(addr_o) && $stable(data_o))); // R5

    AST_SHIFT_ENTRY: assert property (@(posedge sck) disable iff (!rst_n)
        !sel_ld_n |=> (shift_word[0] == $past(sdi))); // R2

    AST_IDLE_HOLD: assert property (@(posedge sck) disable iff (!rst_n)
        sel_ld_n |=> $stable(shift_word)); // R1
endmodule

bind serial_cmd_rx scrx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .sdi        (sdi),
    .sel_ld_n   (sel_ld_n),
    .exec_pulse (exec_pulse),
    .shift_word (shift_word),
    .cmd_o      (cmd_o),
    .addr_o     (addr_o),
    .data_o     (data_o)
);

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sel_ld_n = 1'b1;

    logic        sdo1, sdo2, ex1, ex2;
    logic [3:0]  cmd1, cmd2, adr1, adr2;
    logic [15:0] dat1, dat2;

    int checks = 0;
    int fails  = 0;
    bit live   = 0;

    bit hist1[$];
    bit hist2[$];
    logic [23:0] exp1[$];
    logic [23:0] exp2[$];

    always #2 clk = ~clk;

    serial_cmd_rx dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sel_ld_n(sel_ld_n),
        .sdo(sdo1), .exec_pulse(ex1), .cmd_o(cmd1), .addr_o(adr1), .data_o(dat1)
    );

    serial_cmd_rx dut2 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdo1), .sel_ld_n(sel_ld_n),
        .sdo(sdo2), .exec_pulse(ex2), .cmd_o(cmd2), .addr_o(adr2), .data_o(dat2)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] last24(input bit q[$]);
        logic [23:0] w = '0;
        for (int k = 0; k < 24; k++)
            if (q.size() > k) w[k] = q[q.size()-1-k];
        return w;
    endfunction

    function automatic bit delayed(input bit q[$], input int g);
        return (g >= 32) ? q[g-32] : 1'b0;
    endfunction

    // driver: shifts a frame, checks SDO of both devices, pushes expected words
    task automatic send_frame(input int nbits, input logic [63:0] bits);
        sel_ld_n = 1'b0;
        #6;
        for (int i = nbits - 1; i >= 0; i--) begin
            int e;
            bit s2;
            sdi = bits[i];
            e  = hist1.size() + 1;
            s2 = (e >= 33) ? hist1[e-33] : 1'b0;
            #8 sck = 1'b1;
            hist1.push_back(bits[i]);
            hist2.push_back(s2);
            #10 sck = 1'b0;
            #2;
            check(sdo1 == delayed(hist1, hist1.size()), "R6/R7 sdo dev1", 32'(sdo1), 32'(delayed(hist1, hist1.size())));
            check(sdo2 == delayed(hist2, hist2.size()), "R9 sdo dev2", 32'(sdo2), 32'(delayed(hist2, hist2.size())));
        end
        #6;
        exp1.push_back(last24(hist1));
        exp2.push_back(last24(hist2));
        sel_ld_n = 1'b1;
        #60;
    endtask

    // monitor: pops one expected word per execute pulse
    always @(negedge clk) begin
        if (live) begin
            if (ex1) begin
                if (exp1.size() == 0) check(1'b0, "R5 unexpected pulse dev1", 32'(1), 32'(0));
                else begin
                    logic [23:0] w;
                    w = exp1.pop_front();
                    check({cmd1, adr1, dat1} == w, "R3/R4 fields dev1", 32'({cmd1, adr1, dat1}), 32'(w));
                end
            end
            if (ex2) begin
                if (exp2.size() == 0) check(1'b0, "R5 unexpected pulse dev2", 32'(1), 32'(0));
                else begin
                    logic [23:0] w;
                    w = exp2.pop_front();
                    check({cmd2, adr2, dat2} == w, "R9 fields dev2", 32'({cmd2, adr2, dat2}), 32'(w));
                end
            end
        end
    end

    initial begin
        #2000000;
        check(1'b0, "watchdog", 32'(0), 32'(1));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #11;
        check(sdo1 == 1'b0 && ex1 == 1'b0, "R8 reset outputs", 32'({sdo1, ex1}), 32'(0));
        check({cmd1, adr1, dat1} == 24'h0, "R8 reset fields", 32'({cmd1, adr1, dat1}), 32'(0));
        rst_n = 1'b1;
        #9;
        live = 1;

        // R3/R4: plain 24-bit frame
        send_frame(24, 64'h3_1_A5C3);
        // R4: 32-bit frame with don't-care prefix
        send_frame(32, 64'hFF_0_2_1234);
        check(cmd1 == 4'h0 && adr1 == 4'h2 && dat1 == 16'h1234, "R4 32-bit decode",
              32'({cmd1, adr1, dat1}), 32'h021234);

        // R1: serial clocks while deselected are ignored
        begin
            logic s1h, s2h;
            s1h = sdo1; s2h = sdo2;
            for (int k = 0; k < 10; k++) begin
                sdi = k[0];
                #8 sck = 1'b1;
                #10 sck = 1'b0;
                #2;
                check(sdo1 == s1h && sdo2 == s2h, "R1 idle sdo", 32'({sdo1, sdo2}), 32'({s1h, s2h}));
            end
            #40;
            check(exp1.size() == 0 && exp2.size() == 0, "R1 no execute", 32'(exp1.size()), 32'(0));
        end

        // R9: 64-bit stream, first word for the downstream device
        send_frame(64, {8'h00, 4'h3, 4'h3, 16'hBEEF, 8'hAA, 4'hF, 4'hF, 16'h0000});
        check({cmd2, adr2, dat2} == 24'h33BEEF, "R9 downstream word", 32'({cmd2, adr2, dat2}), 32'h33BEEF);
        check({cmd1, adr1, dat1} == 24'hFF0000, "R9 upstream word", 32'({cmd1, adr1, dat1}), 32'hFF0000);

        // R4: longer frame decodes from last 24 bits
        send_frame(40, 64'hC3_55_7_4_9876);
        check({cmd1, adr1, dat1} == 24'h749876, "R4 40-bit decode", 32'({cmd1, adr1, dat1}), 32'h749876);
        // R7: short frame after long ones keeps pass-through flowing
        send_frame(24, 64'hF_F_FFFF);
        send_frame(24, 64'h1_8_0001);

        #40;
        check(exp1.size() == 0 && exp2.size() == 0, "R5 every strobe executed once",
              32'(exp1.size() + exp2.size()), 32'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule